// File: doc/BRIEF.md
# Receive Character Queue with Line Status

This block sits between a serial deserializer and a host register interface. Each time the deserializer finishes a character, it pulses a completion flag. With that pulse come the eight data bits and three error tags: parity error, framing error and break. The block stores the character and its tags as one entry in a first-in first-out queue, 16 entries deep by default. The host pops characters with a data read strobe. The popped character appears on a registered read-data port.

An 8-bit line status word goes to the host at all times. Bit 0 (data available) is high while the queue holds at least one character. Bit 1 (overrun) is sticky. It is set when a character completes while the queue is full, and that character is dropped. Bits 2, 3 and 4 show the parity-error, framing-error and break tags of the character now at the head of the queue, so each error is seen together with the character it belongs to. A status read strobe clears the overrun indication and hides the head tags until a different character reaches the head. A line-status interrupt request is raised whenever any of bits 1 to 4 is set and the interrupt is enabled.

Top module: `rxq_status_unit`

## Requirements
- R1: Status bit 0 is 1 from the clock edge that accepts a character into an empty queue. It returns to 0 at the edge of the data read that removes the last stored character.
- R2: A data read strobe on a non-empty queue places the head character on `rd_data` at the next clock edge and advances the queue. Characters leave in arrival order, and 16 characters can be held at once.
- R3: A completed character that arrives while the queue holds 16 entries is discarded: the occupancy and stored contents are unchanged. Status bit 1 is set at that same edge.
- R4: Status bits 2 (parity), 3 (framing) and 4 (break) equal the tags stored with the head character. All three are 0 while the queue is empty.
- R5: A status read strobe clears status bit 1 at the next edge. If an overrun occurs in the same cycle, bit 1 stays set.
- R6: After a status read strobe, bits 2 to 4 stay 0 for as long as the same character is at the head. When a new character becomes the head, its own tags are shown.
- R7: A data read strobe on an empty queue leaves `rd_data` and the status word unchanged.
- R8: `line_irq` equals `irq_line_en` ANDed with the OR of status bits 1 to 4, with no added delay.
- R9: Status bits 5 to 7 always read 0. After reset the status word, `rd_data` and `line_irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_done | input | 1 | One-cycle pulse: a character has been fully received |
| char_data | input | 8 | Received data bits |
| char_par | input | 1 | Parity-error tag of the received character |
| char_frm | input | 1 | Framing-error tag of the received character |
| char_brk | input | 1 | Break tag of the received character |
| rd_data_stb | input | 1 | Host data read strobe (pops one character) |
| rd_stat_stb | input | 1 | Host status read strobe (clears the sticky indications) |
| irq_line_en | input | 1 | Enable for the line-status interrupt request |
| rd_data | output | 8 | Registered character from the last data read |
| line_stat | output | 8 | Line status word: 0 available, 1 overrun, 2 parity, 3 framing, 4 break |
| line_irq | output | 1 | Line-status interrupt request |

## Verification
Every stored state changes at the clock edge that samples a strobe or a completion pulse. The status word and `line_irq` are combinational from that state, so a result is due one edge after its stimulus. The same holds for `rd_data`, which is registered and updates at the edge that takes the data read strobe. The bench changes inputs just after a falling edge, lets exactly one rising edge pass, and reads the outputs at the following falling edge. Each expected value is therefore compared against the state one edge after its cause. Cases where two events collide in one cycle (an overrun together with a status read, or a head change together with a status read) are driven in a single cycle so that the priority rule decides the result.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int DATA_W = 8;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [DATA_W-1:0] data;
    } rxq_entry_t;

    typedef struct packed {
        logic [2:0] zero;
        logic       brk;
        logic       frm;
        logic       par;
        logic       ovr;
        logic       avail;
    } rxq_status_t;

    function automatic rxq_status_t build_status(
        input logic       avail,
        input logic       ovr,
        input rxq_entry_t head,
        input logic       hide
    );
        rxq_status_t s;
        logic show;
        show    = avail && !hide;
        s.zero  = 3'b000;
        s.avail = avail;
        s.ovr   = ovr;
        s.par   = show && head.par;
        s.frm   = show && head.frm;
        s.brk   = show && head.brk;
        return s;
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  rxq_entry_t        wr_entry,
    input  logic              pop,
    output rxq_entry_t        head,
    output logic [DATA_W-1:0] rd_q,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     count
);

    rxq_entry_t     mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    logic           push_ok;
    logic           pop_ok;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rd_q   <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= next_ptr(rd_ptr);
                rd_q   <= head.data;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags (
    input  logic clk,
    input  logic rst,
    input  logic ovr_evt,
    input  logic stat_rd,
    input  logic head_change,
    output logic ovr_q,
    output logic hide_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q  <= 1'b0;
            hide_q <= 1'b0;
        end else begin
            if (ovr_evt) begin
                ovr_q <= 1'b1;
            end else if (stat_rd) begin
                ovr_q <= 1'b0;
            end
            if (head_change) begin
                hide_q <= 1'b0;
            end else if (stat_rd) begin
                hide_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxq_status_unit.sv
module rxq_status_unit
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_par,
    input  logic              char_frm,
    input  logic              char_brk,
    input  logic              rd_data_stb,
    input  logic              rd_stat_stb,
    input  logic              irq_line_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [STAT_W-1:0] line_stat,
    output logic              line_irq
);

    rxq_entry_t  wr_entry;
    rxq_entry_t  head;
    rxq_status_t stat;
    logic        fifo_full;
    logic        fifo_empty;
    logic [CW-1:0] occ;
    logic        ovr_evt;
    logic        head_change;
    logic        ovr_q;
    logic        hide_q;

    assign wr_entry = '{brk: char_brk, frm: char_frm, par: char_par, data: char_data};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (char_done),
        .wr_entry (wr_entry),
        .pop      (rd_data_stb),
        .head     (head),
        .rd_q     (rd_data),
        .full     (fifo_full),
        .empty    (fifo_empty),
        .count    (occ)
    );

    // A dropped character marks overrun; a pop or a first write moves the head.
    assign ovr_evt     = char_done && fifo_full;
    assign head_change = (rd_data_stb && !fifo_empty) || (char_done && fifo_empty);

    rxq_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .ovr_evt     (ovr_evt),
        .stat_rd     (rd_stat_stb),
        .head_change (head_change),
        .ovr_q       (ovr_q),
        .hide_q      (hide_q)
    );

    assign stat      = build_status(!fifo_empty, ovr_q, head, hide_q);
    assign line_stat = stat;
    assign line_irq  = irq_line_en && (stat.ovr || stat.par || stat.frm || stat.brk);

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          char_done,
    input logic          rd_data_stb,
    input logic          rd_stat_stb,
    input logic          irq_line_en,
    input logic [7:0]    rd_data,
    input logic [7:0]    line_stat,
    input logic          line_irq,
    input logic          fifo_full,
    input logic [CW-1:0] occ
);

    assert_avail_on_push_R1: assert property (@(posedge clk) disable iff (rst)
        (!line_stat[0] && char_done) |=> line_stat[0]);

    assert_overrun_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && char_done) |=> line_stat[1]);

    assert_overrun_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && char_done && !rd_data_stb) |=> (occ == $past(occ)));

    assert_no_tags_when_empty_R4: assert property (@(posedge clk) disable iff (rst)
        !line_stat[0] |-> (line_stat[4:2] == 3'b000));

    assert_stat_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stat_stb && !(fifo_full && char_done)) |=> !line_stat[1]);

    assert_tags_hidden_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_stat_stb && !rd_data_stb && line_stat[0]) |=> (line_stat[4:2] == 3'b000));

    assert_empty_read_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_data_stb && !line_stat[0] && !char_done) |=> $stable(rd_data));

    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
        !irq_line_en |-> !line_irq);

endmodule

bind rxq_status_unit rxq_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .char_done   (char_done),
    .rd_data_stb (rd_data_stb),
    .rd_stat_stb (rd_stat_stb),
    .irq_line_en (irq_line_en),
    .rd_data     (rd_data),
    .line_stat   (line_stat),
    .line_irq    (line_irq),
    .fifo_full   (fifo_full),
    .occ         (occ)
);

// File: tb/rxq_status_unit_test.sv
`timescale 1ns/1ps
module rxq_status_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       char_done = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_par = 1'b0;
    logic       char_frm = 1'b0;
    logic       char_brk = 1'b0;
    logic       rd_data_stb = 1'b0;
    logic       rd_stat_stb = 1'b0;
    logic       irq_line_en = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] line_stat;
    logic       line_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rxq_status_unit uut (
        .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
        .char_par(char_par), .char_frm(char_frm), .char_brk(char_brk),
        .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
        .irq_line_en(irq_line_en), .rd_data(rd_data),
        .line_stat(line_stat), .line_irq(line_irq)
    );

    // Vector layout: {brk, frm, par, data}
    localparam int NV = 6;
    localparam logic [10:0] VEC [NV] = '{
        {3'b000, 8'hA1},
        {3'b001, 8'h5A},
        {3'b010, 8'h3C},
        {3'b110, 8'h00},
        {3'b011, 8'h7E},
        {3'b000, 8'h99}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] tags);
        char_done = 1'b1;
        char_data = d;
        {char_brk, char_frm, char_par} = tags;
        @(negedge clk);
        char_done = 1'b0;
    endtask

    task automatic read_data();
        rd_data_stb = 1'b1;
        @(negedge clk);
        rd_data_stb = 1'b0;
    endtask

    task automatic read_stat();
        rd_stat_stb = 1'b1;
        @(negedge clk);
        rd_stat_stb = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset status", line_stat, 8'h00);
        chk("R9 reset rd_data", rd_data, 8'h00);
        chk("R9 reset irq", line_irq, 1'b0);

        // R7: read on empty queue right after reset
        read_data();
        chk("R7 empty read rd_data", rd_data, 8'h00);
        chk("R7 empty read status", line_stat, 8'h00);

        // Table walk
        irq_line_en = 1'b1;
        for (int i = 0; i < NV; i++) begin
            push(VEC[i][7:0], VEC[i][10:8]);
            chk("R1 avail after push", line_stat[0], 1'b1);
        end
        for (int i = 0; i < NV; i++) begin
            chk("R4 head tags", line_stat[4:2], VEC[i][10:8]);
            chk("R9 upper bits zero", line_stat[7:5], 3'b000);
            chk("R8 irq follows tags", line_irq, |VEC[i][10:8]);
            read_stat();
            chk("R6 tags hidden after status read", line_stat[4:2], 3'b000);
            read_data();
            chk("R2 data in order", rd_data, VEC[i][7:0]);
        end
        chk("R1 avail clears after last read", line_stat[0], 1'b0);

        // Overrun
        for (int i = 0; i < 16; i++) push(8'h40 + 8'(i), 3'b000);
        chk("R3 no overrun at exactly full", line_stat[1], 1'b0);
        push(8'hEE, 3'b111);
        chk("R3 overrun on extra char", line_stat[1], 1'b1);
        chk("R8 irq on overrun", line_irq, 1'b1);
        irq_line_en = 1'b0;
        #1;
        chk("R8 irq masked", line_irq, 1'b0);
        irq_line_en = 1'b1;
        read_stat();
        chk("R5 status read clears overrun", line_stat[1], 1'b0);
        // Overrun and status read in the same cycle: set wins
        char_done = 1'b1; char_data = 8'hDD; rd_stat_stb = 1'b1;
        @(negedge clk);
        char_done = 1'b0; rd_stat_stb = 1'b0;
        chk("R5 overrun wins over clear", line_stat[1], 1'b1);
        read_stat();
        chk("R5 cleared again", line_stat[1], 1'b0);
        for (int i = 0; i < 16; i++) begin
            read_data();
            chk("R2 full-depth order", rd_data, 8'h40 + 8'(i));
        end
        chk("R3 dropped chars not stored", line_stat[0], 1'b0);
        read_data();
        chk("R7 empty read keeps data", rd_data, 8'h4F);
        chk("R7 empty read keeps status", line_stat, 8'h00);

        // R6: status read in the same cycle as a head change shows new head tags
        push(8'h11, 3'b001);
        push(8'h22, 3'b100);
        rd_stat_stb = 1'b1; rd_data_stb = 1'b1;
        @(negedge clk);
        rd_stat_stb = 1'b0; rd_data_stb = 1'b0;
        chk("R6 new head tags shown", line_stat[4:2], 3'b100);
        read_data();
        chk("R2 last char", rd_data, 8'h22);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule